// File: doc/BRIEF.md
# Interrupt Message Delivery Scanner

This block sits behind the interrupt-source register file of a message-signalled interrupt domain. It finds sources whose enable and pending bits are both set and turns each one into an outgoing message. The message carries a hart index, a guest index and an interrupt identity, all taken from that source's target word. Each delivery pulses a consume strobe with the source number. The pending-bit logic outside the block uses this strobe to clear the bit. The enable bit is never touched.

Any register write starts a full rescan of sources 1 to N-1 in ascending order. A change on a source's wire can also request delivery of that one source right away. A domain-wide enable suppresses all source delivery while it is low.

Software can also write a generate-message word to send a single message without a source. That message always carries guest index 0. The stored word can be read back with its guest field cleared and a busy flag.

Messages leave through a single valid/ready slot. Only one message is held at a time.

Top module: `irq_msg_scanner`

## Requirements
- R1: After reset, msgValid and consumeValid are 0 and genReadback is 0.
- R2: While domainEn is 0, no source is delivered and consumeValid stays 0. Pending bits are therefore kept, and the sources are delivered once the domain is enabled and rescanned.
- R3: A source is delivered only when srcEn and srcPend are both 1 for it. Delivery pulses consumeValid with consumeIdx equal to the source number, in the same cycle the message is captured.
- R4: A source message takes msgHart from target bits [31:18], msgGuest from bits [17:12] and msgEiid from bits [10:0] of that source's 32-bit slice of tgtFlat (source s occupies bits s*32+31 down to s*32).
- R5: A regWrite or genWr pulse restarts a scan of sources 1..N-1 in ascending order, one source per cycle. Source s is examined in the s-th cycle after the write edge. Hits are delivered in ascending source order.
- R6: An evtValid pulse with evtIdx in 1..N-1 delivers that source ahead of any scan, if it is enabled, pending and domainEn is 1. Index 0, out-of-range indices, and events while domainEn is 0 cause no delivery.
- R7: A genWr stores genWrData with bits [17:12] cleared. genReadback returns the stored word with bit 12 used as a busy flag; bit 12 reads 1 from the write until the resulting message is accepted. The message has msgHart = data[31:18], msgGuest = 0 and msgEiid = data[10:0], and it is sent whatever the value of domainEn.
- R8: While msgValid is 1 and msgReady is 0, the message fields hold steady and no further consume pulse occurs.
- R9: A pending generate-message request is served before any source delivery competing for the free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| domainEn | input | 1 | Domain-wide delivery enable |
| srcEn | input | N_SRC | Per-source enable bits (bit 0 unused) |
| srcPend | input | N_SRC | Per-source pending bits (bit 0 unused) |
| tgtFlat | input | 32*N_SRC | Packed target words, one per source |
| regWrite | input | 1 | Pulse: a register write happened, rescan |
| evtValid | input | 1 | Pulse: wire event on source evtIdx |
| evtIdx | input | IDX_W | Source number of the wire event |
| genWr | input | 1 | Pulse: write to the generate-message word |
| genWrData | input | 32 | Value written to the generate-message word |
| genReadback | output | 32 | Stored generate-message word with busy flag in bit 12 |
| msgValid | output | 1 | Message slot holds a message |
| msgReady | input | 1 | Downstream accepts the message |
| msgHart | output | 14 | Message hart index |
| msgGuest | output | 6 | Message guest index |
| msgEiid | output | 11 | Message interrupt identity |
| consumeValid | output | 1 | Pulse: clear pending of consumeIdx |
| consumeIdx | output | IDX_W | Source whose pending bit is consumed |

## Verification
A generate-message write held over edge E0 raises busy in genReadback after E0. Its message shows on msgValid after E1. A register write at E0 examines source s at edge E(s), so that source's message and its consume pulse (which precedes that edge) appear in the window following E(s). A wire event at E0 is served at E1 when the slot is free. The bench drives inputs on falling edges. A behavioural model advances on each rising edge from those held inputs. Registered outputs are compared on the falling edge, where they are settled. The combinational consume strobe is sampled on the falling edge before the rising edge that acts on it. Directed checks then compare the sequence of accepted messages against the ordering rules.

// File: rtl/dlv_pkg.sv
package dlv_pkg;
  // target word field layout, fixed by the message format
  localparam int TGT_W       = 32;
  localparam int HART_LSB    = 18;
  localparam int HART_W      = 14;
  localparam int GUEST_LSB   = 12;
  localparam int GUEST_W     = 6;
  localparam int EIID_W      = 11;
  localparam int BUSY_BIT    = 12;
  localparam int IDX_FIELD_W = 8;

  localparam logic [TGT_W-1:0] GUEST_MASK =
    TGT_W'(((1 << GUEST_W) - 1) << GUEST_LSB);

  // strobes from control to datapath
  typedef struct packed {
    logic                   loadGen;
    logic                   loadSrc;
    logic [IDX_FIELD_W-1:0] srcIdx;
  } dlvStb_t;
endpackage

// File: rtl/dlv_pick.sv
module dlv_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set request wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dlv_ctrl.sv
module dlv_ctrl
  import dlv_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             domainEn,
  input  logic [N_SRC-1:0] srcEn,
  input  logic [N_SRC-1:0] srcPend,
  input  logic             rescanReq,
  input  logic             evtValid,
  input  logic [IDX_W-1:0] evtIdx,
  input  logic             genWr,
  input  logic             msgBusy,
  output dlvStb_t          stb,
  output logic             genPend
);
  localparam int FULL = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(N_SRC - 1);

  logic             genReqQ;
  logic             scanOnQ;
  logic [IDX_W-1:0] scanIdxQ;
  logic [N_SRC-1:0] hintQ;

  logic             hintAny;
  logic [IDX_W-1:0] hintIdx;
  logic             slotFree, doGen, doHint, doScan, hit;
  logic [IDX_W-1:0] chkIdx;
  logic [FULL-1:0]  readyFull, evtFull, servedFull;
  logic [N_SRC-1:0] evtMask, servedMask;

  dlv_pick #(.N(N_SRC), .IDX_W(IDX_W)) i_pick (
    .req (hintQ),
    .any (hintAny),
    .idx (hintIdx)
  );

  always_comb begin
    readyFull  = FULL'(srcEn & srcPend);
    slotFree   = !msgBusy;
    doGen      = slotFree && genReqQ;
    doHint     = slotFree && !genReqQ && domainEn && hintAny;
    doScan     = slotFree && !genReqQ && domainEn && !hintAny && scanOnQ;
    chkIdx     = doHint ? hintIdx : scanIdxQ;
    hit        = (doHint || doScan) && readyFull[chkIdx];
    evtFull    = FULL'(1) << evtIdx;
    evtMask    = evtValid ? (N_SRC'(evtFull) & ~N_SRC'(1)) : '0;
    servedFull = FULL'(1) << hintIdx;
    servedMask = doHint ? N_SRC'(servedFull) : '0;
  end

  always_comb begin
    stb.loadGen = doGen;
    stb.loadSrc = hit;
    stb.srcIdx  = IDX_FIELD_W'(chkIdx);
  end

  assign genPend = genReqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genReqQ  <= 1'b0;
      scanOnQ  <= 1'b0;
      scanIdxQ <= FIRST_IDX;
      hintQ    <= '0;
    end else begin
      if (genWr)      genReqQ <= 1'b1;
      else if (doGen) genReqQ <= 1'b0;

      if (!domainEn) hintQ <= '0;
      else           hintQ <= (hintQ & ~servedMask) | evtMask;

      if (rescanReq) begin
        scanOnQ  <= 1'b1;
        scanIdxQ <= FIRST_IDX;
      end else if (!domainEn) begin
        scanOnQ <= 1'b0;
      end else if (doScan) begin
        if (scanIdxQ == LAST_IDX) scanOnQ <= 1'b0;
        else                      scanIdxQ <= scanIdxQ + IDX_W'(1);
      end
    end
  end

  // R2: no source delivery while the domain is disabled
  a_r2_quiet_domain: assert property (@(posedge clk) disable iff (!rstN)
    !domainEn |-> !stb.loadSrc);

  // R5: delivered source numbers stay inside 1..N-1
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadSrc |-> (stb.srcIdx != '0) && (int'(stb.srcIdx) < N_SRC));

  // R9: a waiting generate request never loses the slot to a source
  a_r9_gen_first: assert property (@(posedge clk) disable iff (!rstN)
    (genPend && !msgBusy) |-> (stb.loadGen && !stb.loadSrc));
endmodule

// File: rtl/dlv_path.sv
module dlv_path
  import dlv_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dlvStb_t            stb,
  input  logic               genPend,
  input  logic               genWr,
  input  logic [TGT_W-1:0]   genWrData,
  input  logic [N_SRC*TGT_W-1:0] tgtFlat,
  input  logic               msgReady,
  output logic               msgValid,
  output logic [HART_W-1:0]  msgHart,
  output logic [GUEST_W-1:0] msgGuest,
  output logic [EIID_W-1:0]  msgEiid,
  output logic               consumeValid,
  output logic [IDX_W-1:0]   consumeIdx,
  output logic [TGT_W-1:0]   genReadback
);
  localparam int FULL = 2 ** IDX_W;

  logic [TGT_W-1:0]   tgtArr [FULL];
  logic [TGT_W-1:0]   tgtSel;
  logic [TGT_W-1:0]   genStoreQ;
  logic               msgValidQ, msgIsGenQ;
  logic [HART_W-1:0]  msgHartQ;
  logic [GUEST_W-1:0] msgGuestQ;
  logic [EIID_W-1:0]  msgEiidQ;
  logic               busy;

  for (genvar g = 0; g < FULL; g++) begin : g_tgt
    if (g < N_SRC) begin : g_real
      assign tgtArr[g] = tgtFlat[g*TGT_W +: TGT_W];
    end else begin : g_none
      assign tgtArr[g] = '0;
    end
  end

  assign tgtSel = tgtArr[stb.srcIdx[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genStoreQ <= '0;
      msgValidQ <= 1'b0;
      msgIsGenQ <= 1'b0;
      msgHartQ  <= '0;
      msgGuestQ <= '0;
      msgEiidQ  <= '0;
    end else begin
      if (genWr) genStoreQ <= genWrData & ~GUEST_MASK;

      if (stb.loadGen) begin
        msgValidQ <= 1'b1;
        msgIsGenQ <= 1'b1;
        msgHartQ  <= genStoreQ[HART_LSB +: HART_W];
        msgGuestQ <= '0;
        msgEiidQ  <= genStoreQ[EIID_W-1:0];
      end else if (stb.loadSrc) begin
        msgValidQ <= 1'b1;
        msgIsGenQ <= 1'b0;
        msgHartQ  <= tgtSel[HART_LSB +: HART_W];
        msgGuestQ <= tgtSel[GUEST_LSB +: GUEST_W];
        msgEiidQ  <= tgtSel[EIID_W-1:0];
      end else if (msgValidQ && msgReady) begin
        msgValidQ <= 1'b0;
      end
    end
  end

  assign busy         = genPend || (msgValidQ && msgIsGenQ);
  assign genReadback  = genStoreQ | (TGT_W'(busy) << BUSY_BIT);
  assign msgValid     = msgValidQ;
  assign msgHart      = msgHartQ;
  assign msgGuest     = msgGuestQ;
  assign msgEiid      = msgEiidQ;
  assign consumeValid = stb.loadSrc;
  assign consumeIdx   = stb.srcIdx[IDX_W-1:0];

  // R8: a stalled message holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (msgValidQ && !msgReady) |=> (msgValidQ && $stable(msgHartQ)
      && $stable(msgGuestQ) && $stable(msgEiidQ)));

  // R8: no consume while the slot is occupied
  a_r8_no_consume_busy: assert property (@(posedge clk) disable iff (!rstN)
    msgValidQ |-> !consumeValid);

  // R3: every consume pulse is followed by a presented message
  a_r3_consume_loads: assert property (@(posedge clk) disable iff (!rstN)
    consumeValid |=> msgValidQ);

  // R7: software messages always carry guest index zero
  a_r7_guest_zero: assert property (@(posedge clk) disable iff (!rstN)
    (msgValidQ && msgIsGenQ) |-> (msgGuestQ == '0));
endmodule

// File: rtl/irq_msg_scanner.sv
module irq_msg_scanner
  import dlv_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   domainEn,
  input  logic [N_SRC-1:0]       srcEn,
  input  logic [N_SRC-1:0]       srcPend,
  input  logic [N_SRC*32-1:0]    tgtFlat,
  input  logic                   regWrite,
  input  logic                   evtValid,
  input  logic [IDX_W-1:0]       evtIdx,
  input  logic                   genWr,
  input  logic [31:0]            genWrData,
  output logic [31:0]            genReadback,
  output logic                   msgValid,
  input  logic                   msgReady,
  output logic [13:0]            msgHart,
  output logic [5:0]             msgGuest,
  output logic [10:0]            msgEiid,
  output logic                   consumeValid,
  output logic [IDX_W-1:0]       consumeIdx
);
  dlvStb_t stb;
  logic    genPend;

  dlv_ctrl #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .domainEn  (domainEn),
    .srcEn     (srcEn),
    .srcPend   (srcPend),
    .rescanReq (regWrite || genWr),
    .evtValid  (evtValid),
    .evtIdx    (evtIdx),
    .genWr     (genWr),
    .msgBusy   (msgValid),
    .stb       (stb),
    .genPend   (genPend)
  );

  dlv_path #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .genPend      (genPend),
    .genWr        (genWr),
    .genWrData    (genWrData),
    .tgtFlat      (tgtFlat),
    .msgReady     (msgReady),
    .msgValid     (msgValid),
    .msgHart      (msgHart),
    .msgGuest     (msgGuest),
    .msgEiid      (msgEiid),
    .consumeValid (consumeValid),
    .consumeIdx   (consumeIdx),
    .genReadback  (genReadback)
  );
endmodule

// File: tb/test_irq_msg_scanner.sv
module test_irq_msg_scanner;
  localparam int NS = 8;
  localparam int IW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic domainEn = 1'b0;
  logic [NS-1:0] srcEn = '0;
  logic [NS-1:0] mPend;
  logic [NS-1:0] setMask = '0;
  logic [NS*32-1:0] tgtFlat;
  logic regWrite = 1'b0, evtValid = 1'b0, genWr = 1'b0, msgReady = 1'b1;
  logic [IW-1:0] evtIdx = '0;
  logic [31:0] genWrData = '0;
  logic [31:0] genReadback;
  logic msgValid, consumeValid;
  logic [13:0] msgHart;
  logic [5:0] msgGuest;
  logic [10:0] msgEiid;
  logic [IW-1:0] consumeIdx;

  always #10 clk = ~clk;

  irq_msg_scanner #(.N_SRC(NS)) i_irq_msg_scanner (
    .clk(clk), .rstN(rstN), .domainEn(domainEn), .srcEn(srcEn), .srcPend(mPend),
    .tgtFlat(tgtFlat), .regWrite(regWrite), .evtValid(evtValid), .evtIdx(evtIdx),
    .genWr(genWr), .genWrData(genWrData), .genReadback(genReadback),
    .msgValid(msgValid), .msgReady(msgReady), .msgHart(msgHart), .msgGuest(msgGuest),
    .msgEiid(msgEiid), .consumeValid(consumeValid), .consumeIdx(consumeIdx)
  );

  function automatic logic [31:0] mkTgt(int hart, int guest, int eiid);
    return (32'(hart) << 18) | (32'(guest & 63) << 12) | 32'(eiid & 2047);
  endfunction

  function automatic logic [30:0] fld(logic [31:0] t);
    return {t[31:18], t[17:12], t[10:0]};
  endfunction

  // counters, one pair per process
  int pChk = 0, pFail = 0, nChk = 0, nFail = 0, dChk = 0, dFail = 0;
  int consSeen = 0;
  logic [30:0] got [$];
  logic snapCons;
  logic [IW-1:0] snapIdx;

  // behavioural reference state
  logic mValid, mGenReq, mIsGen, mScanOn;
  int mScanPos;
  logic [NS-1:0] mHint;
  logic [13:0] mHart;
  logic [5:0] mGuest;
  logic [10:0] mEiid;
  logic [31:0] mGenStore;

  always @(posedge clk) begin : model
    logic free, gDo, hDo, sDo, hit, anyH;
    logic [31:0] t;
    int c;
    if (!rstN) begin
      mValid <= 0; mGenReq <= 0; mIsGen <= 0; mScanOn <= 0; mScanPos <= 1;
      mHint <= '0; mPend <= '0; mHart <= '0; mGuest <= '0; mEiid <= '0; mGenStore <= '0;
    end else begin
      anyH = domainEn && (mHint != '0);
      free = !mValid;
      gDo  = free && mGenReq;
      hDo  = free && !mGenReq && anyH;
      sDo  = free && !mGenReq && !anyH && domainEn && mScanOn;
      c = mScanPos;
      if (hDo) for (int k = NS - 1; k >= 1; k--) if (mHint[k]) c = k;
      hit = (hDo || sDo) && srcEn[c] && mPend[c];
      pChk++;
      if (snapCons !== hit || (hit && int'(snapIdx) != c)) begin
        pFail++;
        $display("FAIL R3 consume act=%0b/%0d exp=%0b/%0d", snapCons, snapIdx, hit, c);
      end
      if (genWr) mGenStore <= genWrData & ~32'h0003_F000;
      if (gDo) begin
        mValid <= 1; mIsGen <= 1; mHart <= mGenStore[31:18]; mGuest <= '0; mEiid <= mGenStore[10:0];
      end else if (hit) begin
        t = tgtFlat[c*32 +: 32];
        mValid <= 1; mIsGen <= 0; mHart <= t[31:18]; mGuest <= t[17:12]; mEiid <= t[10:0];
      end else if (mValid && msgReady) mValid <= 0;
      if (genWr) mGenReq <= 1; else if (gDo) mGenReq <= 0;
      if (!domainEn) mHint <= '0;
      else begin
        logic [NS-1:0] h;
        h = mHint;
        if (hDo) h[c] = 1'b0;
        if (evtValid && evtIdx != 0 && int'(evtIdx) < NS) h[evtIdx] = 1'b1;
        mHint <= h;
      end
      if (regWrite || genWr) begin mScanOn <= 1; mScanPos <= 1; end
      else if (!domainEn) mScanOn <= 0;
      else if (sDo) begin
        if (mScanPos == NS - 1) mScanOn <= 0; else mScanPos <= mScanPos + 1;
      end
      mPend <= (mPend & ~(hit ? (NS'(1) << c) : '0)) | setMask;
    end
  end

  always @(negedge clk) begin
    logic [31:0] expRb;
    snapCons = consumeValid;
    snapIdx  = consumeIdx;
    if (rstN) begin
      nChk++;
      if (msgValid !== mValid) begin
        nFail++; $display("FAIL R8 msgValid act=%0b exp=%0b", msgValid, mValid);
      end
      if (mValid) begin
        nChk++;
        if ({msgHart, msgGuest, msgEiid} !== {mHart, mGuest, mEiid}) begin
          nFail++; $display("FAIL R4 fields act=%h exp=%h", {msgHart, msgGuest, msgEiid}, {mHart, mGuest, mEiid});
        end
      end
      expRb = mGenStore | ((mGenReq || (mValid && mIsGen)) ? 32'h1000 : 32'h0);
      nChk++;
      if (genReadback !== expRb) begin
        nFail++; $display("FAIL R7 readback act=%h exp=%h", genReadback, expRb);
      end
      if (msgValid && msgReady) got.push_back({msgHart, msgGuest, msgEiid});
      if (consumeValid) consSeen++;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    dChk++;
    if (!ok) begin
      dFail++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseWrite();
    regWrite = 1; cyc(1); regWrite = 0;
  endtask

  task automatic setPend(logic [NS-1:0] m);
    setMask = m; cyc(1); setMask = '0;
  endtask

  task automatic event1(int idx);
    evtValid = 1; evtIdx = IW'(idx); cyc(1); evtValid = 0;
  endtask

  task automatic gotIs(int base, logic [30:0] exp [$], string tag);
    chk(got.size() == base + exp.size(), tag, 64'(got.size() - base), 64'(exp.size()));
    for (int i = 0; i < exp.size(); i++)
      if (base + i < got.size()) chk(got[base + i] == exp[i], tag, 64'(got[base + i]), 64'(exp[i]));
  endtask

  function automatic logic [30:0] srcMsg(int s);
    return fld(tgtFlat[s*32 +: 32]);
  endfunction

  initial begin
    bit timeout = 0;
    int base, cs;
    logic [31:0] d1, d2;
    for (int s = 0; s < NS; s++) tgtFlat[s*32 +: 32] = mkTgt(100 + s, s, s * 7 + 1);
    fork
      begin
        cyc(4);
        chk(msgValid == 0 && consumeValid == 0 && genReadback == 0, "R1 reset state",
            {msgValid, consumeValid, genReadback}, 64'h0);
        rstN = 1; cyc(2);

        // R2: disabled domain keeps pending bits, sends nothing
        srcEn = 8'hFE; setPend(8'b0010_1000); pulseWrite(); cyc(15);
        chk(got.size() == 0 && consSeen == 0, "R2 no delivery while disabled", 64'(got.size()), 64'h0);

        // R5/R4/R2: enabling plus a write delivers 3 then 5
        base = got.size();
        domainEn = 1; pulseWrite(); cyc(15);
        gotIs(base, '{srcMsg(3), srcMsg(5)}, "R5 ascending order / R4 fields");

        // R3: only enabled and pending sources
        base = got.size();
        srcEn = 8'hEE; setPend(8'b0101_0000); pulseWrite(); cyc(15);
        gotIs(base, '{srcMsg(6)}, "R3 disabled source skipped");
        base = got.size();
        srcEn = 8'hFE; pulseWrite(); cyc(15);
        gotIs(base, '{srcMsg(4)}, "R3 kept pending delivered after enable");

        // R8: back-pressure
        base = got.size(); cs = consSeen;
        msgReady = 0; setPend(8'b0000_0110); pulseWrite(); cyc(10);
        chk(consSeen - cs == 1, "R8 single consume while stalled", 64'(consSeen - cs), 64'h1);
        chk(msgValid == 1 && {msgHart, msgGuest, msgEiid} == srcMsg(1), "R8 message held",
            {msgHart, msgGuest, msgEiid}, 64'(srcMsg(1)));
        msgReady = 1; cyc(10);
        gotIs(base, '{srcMsg(1), srcMsg(2)}, "R8 drain after stall");

        // R7: software message with domain disabled
        base = got.size();
        domainEn = 0; pulseWrite(); cyc(3);
        msgReady = 0;
        d1 = mkTgt(77, 63, 11'h155);
        genWrData = d1; genWr = 1; cyc(1); genWr = 0;
        chk(genReadback == ((d1 & ~32'h3F000) | 32'h1000), "R7 stored word with busy",
            64'(genReadback), 64'((d1 & ~32'h3F000) | 32'h1000));
        cyc(1);
        chk(msgValid == 1 && msgGuest == 0 && msgHart == 14'd77 && msgEiid == 11'h155, "R7 message guest zero",
            {msgHart, msgGuest, msgEiid}, {14'd77, 6'd0, 11'h155});
        msgReady = 1; cyc(1);
        chk(genReadback == (d1 & ~32'h3F000), "R7 busy clears after accept",
            64'(genReadback), 64'(d1 & ~32'h3F000));
        gotIs(base, '{{14'd77, 6'd0, 11'h155}}, "R7 single software message");

        // R9: generate request beats the scan
        domainEn = 1; pulseWrite(); cyc(12);
        base = got.size();
        d2 = mkTgt(5, 9, 33);
        setMask = 8'b0000_1100; genWrData = d2; genWr = 1; cyc(1);
        genWr = 0; setMask = '0; cyc(20);
        gotIs(base, '{{14'd5, 6'd0, 11'd33}, srcMsg(2), srcMsg(3)}, "R9 generate first");

        // R6: wire events
        base = got.size();
        setPend(8'b0010_0000); cyc(6);
        chk(got.size() == base, "R6 no delivery without trigger", 64'(got.size() - base), 64'h0);
        event1(5); cyc(6);
        gotIs(base, '{srcMsg(5)}, "R6 event delivers source");
        base = got.size();
        setPend(8'b0000_0010); event1(9); event1(0); cyc(6);
        chk(got.size() == base, "R6 out of range and zero ignored", 64'(got.size() - base), 64'h0);
        domainEn = 0; event1(1); cyc(6);
        chk(got.size() == base, "R6 event ignored while disabled", 64'(got.size() - base), 64'h0);
        domainEn = 1; event1(1); cyc(6);
        gotIs(base, '{srcMsg(1)}, "R6 event after re-enable");
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) chk(0, "watchdog expired", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", (pChk + nChk + dChk) - (pFail + nFail + dFail), pChk + nChk + dChk);
    $finish;
  end
endmodule